// File: doc/BRIEF.md
# Short I/O Slave Cycle Decoder

This block sits on the slave side of a VMEbus card that bridges 16-bit short I/O cycles to a narrow parallel I/O bus. It claims one 1 KB window of the 64 KB short I/O space. A static 6-bit select input, compared against address lines A15..A10, picks the window. A static privilege input decides which address modifier codes are honoured. Inside the window it responds only on the odd byte lane, which is strobed by DS0. Each 8-bit I/O bank sits at an odd offset. Two further odd offsets are write-only strobes that drive or release the reset line of the I/O bus.

The block resynchronises every bus input through two flip-flops and then classifies the access. A bank access is sent to a downstream sequencer over a valid/acknowledge handshake, carrying the bank number, the direction and the write byte. DTACK follows that acknowledge. A reset-strobe write is acknowledged locally. Every other access in the window, and every access outside it, gets no DTACK, so the master's bus timeout ends it. DTACK is released as soon as the resynchronised DS0 is seen negated.

Top module: `vme_sio_decoder`

## Requirements
- R1: An access is decoded only when A15..A10 equal `base_sel`. Any other value gets no DTACK and no request.
- R2: With `sup_only` = 1, only address modifier 2DH is honoured. With `sup_only` = 0, both 2DH and 29H are honoured. Every other modifier gets no DTACK and no request.
- R3: DS0 must be asserted (low) for any response. An access that strobes only the even lane gets no DTACK and no request. A word access that strobes both lanes is treated exactly like an odd-byte access at the same word address, and `bus_din` carries the data byte.
- R4: Offset 2n+1 of the window (A9..A7 = 0, A6..A1 = n) issues a request with `req_bank` = n, `req_write` = 1 when `write_n` is low, and `req_wdata` = the data byte sampled during the cycle.
- R5: `req_valid` stays high with all request fields stable until `req_ack` is high at a clock edge. DTACK for a bank access is asserted only after that acknowledge and is never low while `req_valid` is high.
- R6: On a bank read, while DTACK is low, `bus_doe` is 1 and `bus_dout` holds the `seq_rdata` value that was present with the acknowledge.
- R7: `ext_reset_n` is 0 after reset. A write to offset 81H drives it to 0 and a write to offset C1H drives it to 1. Each of these writes gets DTACK and issues no request.
- R8: A read of 81H or C1H, and any access to an offset above 7FH other than the two reset strobes, gets no DTACK and no request, and leaves `ext_reset_n` unchanged.
- R9: After DS0 is negated, DTACK is high by the second rising clock edge. No new access is started until DS0 has been seen negated.
- R10: For an accepted bank access, `req_valid` first rises on the third rising edge after AS and DS0 are both asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_sel | input | 6 | Static window select, compared with A15..A10 |
| sup_only | input | 1 | Static: 1 honours the supervisory modifier only |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds0_n | input | 1 | Odd-lane data strobe, active low, asynchronous |
| write_n | input | 1 | Bus direction, low means write |
| addr | input | 15 | Bus address lines A15..A1 |
| am | input | 6 | Address modifier code |
| bus_din | input | 8 | Bus data lines D07..D00 as driven by the master |
| dtack_n | output | 1 | Data transfer acknowledge, active low |
| bus_dout | output | 8 | Read data for D07..D00 |
| bus_doe | output | 1 | Drive enable for `bus_dout` |
| req_valid | output | 1 | Request to the sequencer is pending |
| req_write | output | 1 | Request direction, 1 = write |
| req_bank | output | 6 | Bank number of the request |
| req_wdata | output | 8 | Write byte of the request |
| req_ack | input | 1 | Sequencer accepts the request, one-cycle pulse |
| seq_rdata | input | 8 | Read byte from the sequencer, valid with `req_ack` |
| ext_reset_n | output | 1 | Reset line to the I/O bus, active low |

## Verification
The bench targets the edges of the window decode:
- bank 0 at 01H and bank 63 at 7FH;
- the first offsets past the bank range (81H, 83H, C1H and 101H);
- a word access at an even address next to an even-only access at the same address;
- the two modifier codes under each privilege setting.

A decoder with an off-by-one offset would return the wrong `req_bank`. One that ignored direction on the reset strobes would toggle `ext_reset_n` on a read. One that tested DS1 rather than DS0 would answer even-only cycles. The bench also times the request against the strobe edge and the DTACK release against DS0 negation. A missing synchroniser stage, or a release held one cycle too long, therefore shows up as a failed cycle-count check. The sequencer acknowledge arrives after a random delay, which catches request fields that move, or a DTACK issued before the acknowledge.

// File: rtl/vsio_pkg.sv
package vsio_pkg;

    // Address modifier codes for short I/O cycles
    localparam logic [5:0] AM_SUPV = 6'h2D;
    localparam logic [5:0] AM_USER = 6'h29;

    // Byte offsets of the write-only reset strobes inside the window
    localparam int RST_ON_BYTE  = 'h81;
    localparam int RST_OFF_BYTE = 'hC1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_ACK,
        ST_SKIP
    } vsio_state_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_BANK,
        K_RST_ON,
        K_RST_OFF
    } vsio_kind_e;

endpackage

// File: rtl/vsio_sync.sv
module vsio_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= RST_VAL;
        else        stg_q[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= RST_VAL;
            else        stg_q[i] <= stg_q[i-1];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/vsio_decode.sv
module vsio_decode
    import vsio_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 6,
    parameter int BANK_W = 6
) (
    input  logic [ADDR_W-1:1] addr,
    input  logic [5:0]        am,
    input  logic [SEL_W-1:0]  base_sel,
    input  logic              sup_only,
    input  logic              wr,
    output vsio_kind_e        kind,
    output logic [BANK_W-1:0] bank
);

    // Word offset bits inside the window (A9..A1 by default)
    localparam int OFS_W = ADDR_W - SEL_W - 1;
    localparam logic [OFS_W-1:0] OFS_RST_ON  = OFS_W'(RST_ON_BYTE  >> 1);
    localparam logic [OFS_W-1:0] OFS_RST_OFF = OFS_W'(RST_OFF_BYTE >> 1);

    logic [OFS_W-1:0] ofs;
    logic             hit_blk;
    logic             am_ok;
    logic             in_banks;

    assign ofs      = addr[OFS_W:1];
    assign hit_blk  = (addr[ADDR_W-1 -: SEL_W] == base_sel);          // R1
    assign am_ok    = (am == AM_SUPV) || (!sup_only && am == AM_USER); // R2
    assign in_banks = (ofs[OFS_W-1:BANK_W] == '0);                     // R4
    assign bank     = ofs[BANK_W-1:0];

    always_comb begin
        kind = K_NONE;
        if (hit_blk && am_ok) begin
            if (in_banks)                      kind = K_BANK;
            else if (wr && ofs == OFS_RST_ON)  kind = K_RST_ON;   // R7
            else if (wr && ofs == OFS_RST_OFF) kind = K_RST_OFF;  // R7, R8
        end
    end

endmodule

// File: rtl/vme_sio_decoder.sv
module vme_sio_decoder
    import vsio_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 6,
    parameter int BANK_W = 6,
    parameter int DATA_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  base_sel,
    input  logic              sup_only,
    input  logic              as_n,
    input  logic              ds0_n,
    input  logic              write_n,
    input  logic [ADDR_W-1:1] addr,
    input  logic [5:0]        am,
    input  logic [DATA_W-1:0] bus_din,
    output logic              dtack_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              req_valid,
    output logic              req_write,
    output logic [BANK_W-1:0] req_bank,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              req_ack,
    input  logic [DATA_W-1:0] seq_rdata,
    output logic              ext_reset_n
);

    localparam int SYNC_W = 3 + (ADDR_W - 1) + 6 + DATA_W;

    typedef struct packed {
        vsio_state_e       st;
        logic [BANK_W-1:0] bank;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rst_out_n;
    } regs_t;

    // Two-stage resynchronisation of every bus input (R10)
    logic [SYNC_W-1:0] raw_bus, syn_bus;
    logic              as_s, ds0_s, wrn_s;
    logic [ADDR_W-1:1] addr_s;
    logic [5:0]        am_s;
    logic [DATA_W-1:0] data_s;

    assign raw_bus = {as_n, ds0_n, write_n, addr, am, bus_din};

    vsio_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_N),
        .RST_VAL ({SYNC_W{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_bus),
        .dout (syn_bus)
    );

    assign {as_s, ds0_s, wrn_s, addr_s, am_s, data_s} = syn_bus;

    vsio_kind_e        dec_kind;
    logic [BANK_W-1:0] dec_bank;

    vsio_decode #(
        .ADDR_W(ADDR_W),
        .SEL_W (SEL_W),
        .BANK_W(BANK_W)
    ) u_dec (
        .addr    (addr_s),
        .am      (am_s),
        .base_sel(base_sel),
        .sup_only(sup_only),
        .wr      (!wrn_s),
        .kind    (dec_kind),
        .bank    (dec_bank)
    );

    regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                // Start only on a fresh strobe; DS0 is mandatory (R3)
                if (!as_s && !ds0_s) begin
                    r_d.bank  = dec_bank;
                    r_d.wr    = !wrn_s;
                    r_d.wdata = data_s;
                    unique case (dec_kind)
                        K_BANK:    r_d.st = ST_REQ;
                        K_RST_ON:  begin r_d.rst_out_n = 1'b0; r_d.st = ST_ACK; end
                        K_RST_OFF: begin r_d.rst_out_n = 1'b1; r_d.st = ST_ACK; end
                        default:   r_d.st = ST_SKIP;   // R8: no DTACK
                    endcase
                end
            end
            ST_REQ: begin
                // R5: hold request until the sequencer takes it
                if (req_ack) begin
                    r_d.rdata = seq_rdata;
                    r_d.st    = ST_ACK;
                end
            end
            ST_ACK, ST_SKIP: begin
                // R9: wait for DS0 negation before the next access
                if (ds0_s) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, bank: '0, wr: 1'b0, wdata: '0,
                     rdata: '0, rst_out_n: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    // DTACK drops as soon as the synchronised DS0 shows negation (R9)
    assign dtack_n     = !((r_q.st == ST_ACK) && !ds0_s);
    assign bus_doe     = (r_q.st == ST_ACK) && !ds0_s && !r_q.wr;
    assign bus_dout    = r_q.rdata;
    assign req_valid   = (r_q.st == ST_REQ);
    assign req_write   = r_q.wr;
    assign req_bank    = r_q.bank;
    assign req_wdata   = r_q.wdata;
    assign ext_reset_n = r_q.rst_out_n;

endmodule

// File: rtl/vme_sio_decoder_chk.sv
module vme_sio_decoder_chk #(
    parameter int BANK_W = 6,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ds0_n,
    input logic              dtack_n,
    input logic              req_valid,
    input logic              req_ack,
    input logic              req_write,
    input logic [BANK_W-1:0] req_bank,
    input logic [DATA_W-1:0] req_wdata,
    input logic              bus_doe,
    input logic [DATA_W-1:0] bus_dout,
    input logic              ext_reset_n
);

    // R5: request held stable until acknowledged
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ack |=> req_valid && $stable(req_bank)
                                 && $stable(req_write) && $stable(req_wdata));

    // R5: DTACK never overlaps a pending request
    a_r5_no_early_dtack: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> !req_valid);

    // R6: read data held while it is driven
    a_r6_rdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe && $past(bus_doe) |-> $stable(bus_dout));

    // R7: reset line changes only outside a sequencer request
    a_r7_rst_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ext_reset_n) |-> !req_valid && !$past(req_valid));

    // R9: DTACK released two edges after DS0 negation
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        ds0_n && $past(ds0_n) && $past(ds0_n, 2) |-> dtack_n);

endmodule

bind vme_sio_decoder vme_sio_decoder_chk #(
    .BANK_W(BANK_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ds0_n      (ds0_n),
    .dtack_n    (dtack_n),
    .req_valid  (req_valid),
    .req_ack    (req_ack),
    .req_write  (req_write),
    .req_bank   (req_bank),
    .req_wdata  (req_wdata),
    .bus_doe    (bus_doe),
    .bus_dout   (bus_dout),
    .ext_reset_n(ext_reset_n)
);

// File: tb/vme_sio_decoder_bench.sv
`timescale 1ns/1ps
module vme_sio_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  base_sel = 6'h04;
    logic        sup_only = 1'b1;
    logic        as_n = 1'b1;
    logic        ds0_n = 1'b1;
    logic        write_n = 1'b1;
    logic [15:1] addr = '0;
    logic [5:0]  am = '0;
    logic [7:0]  bus_din = '0;
    logic        dtack_n;
    logic [7:0]  bus_dout;
    logic        bus_doe;
    logic        req_valid;
    logic        req_write;
    logic [5:0]  req_bank;
    logic [7:0]  req_wdata;
    logic        req_ack = 1'b0;
    logic [7:0]  seq_rdata = '0;
    logic        ext_reset_n;

    int checks = 0;
    int fails  = 0;
    bit exp_rst_n = 1'b0;

    bit         got_req = 1'b0;
    logic [5:0] got_bank;
    bit         got_wr;
    logic [7:0] got_wdata;

    always #4 clk = ~clk;

    vme_sio_decoder u_vme_sio_decoder (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .sup_only(sup_only),
        .as_n(as_n), .ds0_n(ds0_n), .write_n(write_n), .addr(addr), .am(am),
        .bus_din(bus_din), .dtack_n(dtack_n), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_wdata(req_wdata), .req_ack(req_ack),
        .seq_rdata(seq_rdata), .ext_reset_n(ext_reset_n)
    );

    function automatic logic [7:0] rd_model(input logic [5:0] b);
        return {2'b00, b} ^ 8'h5A;
    endfunction

    // 0 none, 1 bank, 2 reset on, 3 reset off
    function automatic int exp_kind(input logic [15:0] a, input logic [5:0] m,
                                    input bit ds0, input bit wr);
        logic [8:0] ofs;
        ofs = a[9:1];
        if (!ds0) return 0;                                   // R3
        if (a[15:10] != base_sel) return 0;                   // R1
        if (!(m == 6'h2D || (!sup_only && m == 6'h29))) return 0; // R2
        if (ofs[8:6] == 3'b000) return 1;                     // R4
        if (wr && ofs == 9'h040) return 2;                    // R7
        if (wr && ofs == 9'h060) return 3;                    // R7
        return 0;                                             // R8
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Sequencer model: acknowledges after a random delay
    initial begin
        forever begin
            @(negedge clk);
            if (req_valid) begin
                repeat ($urandom_range(0, 3)) @(negedge clk);
                got_req   = 1'b1;
                got_bank  = req_bank;
                got_wr    = req_write;
                got_wdata = req_wdata;
                seq_rdata = rd_model(req_bank);
                req_ack   = 1'b1;
                @(negedge clk);
                req_ack   = 1'b0;
            end
        end
    end

    task automatic bus_cycle(input logic [15:0] a, input logic [5:0] m,
                             input bit ds0, input bit wr, input logic [7:0] d,
                             input string tag);
        int k;
        int n;
        k = exp_kind(a, m, ds0, wr);
        @(negedge clk);
        got_req = 1'b0;
        addr    = a[15:1];
        am      = m;
        write_n = !wr;
        bus_din = d;
        as_n    = 1'b0;
        ds0_n   = !ds0;
        if (k == 1) begin
            repeat (2) @(posedge clk);
            #1 chk(req_valid == 1'b0, "R10", "req_valid after 2 edges", req_valid, 0);
            @(posedge clk);
            #1 chk(req_valid == 1'b1, "R10", "req_valid after 3 edges", req_valid, 1);
        end
        n = 0;
        while (dtack_n && n < 24) begin
            @(negedge clk);
            n++;
        end
        if (k == 0) begin
            chk(dtack_n == 1'b1, tag, "no DTACK expected", dtack_n, 1);
            chk(got_req == 1'b0, tag, "no request expected", got_req, 0);
            chk(ext_reset_n == exp_rst_n, "R8", "reset line unchanged", ext_reset_n, exp_rst_n);
        end else begin
            chk(dtack_n == 1'b0, tag, "DTACK expected", dtack_n, 0);
            if (k == 1) begin
                chk(got_req == 1'b1, "R5", "request seen", got_req, 1);
                chk(got_bank == a[6:1], "R4", "bank number", got_bank, a[6:1]);
                chk(got_wr == wr, "R4", "direction", got_wr, wr);
                if (wr) chk(got_wdata == d, "R4", "write byte", got_wdata, d);
                else begin
                    chk(bus_doe == 1'b1, "R6", "drive enable", bus_doe, 1);
                    chk(bus_dout == rd_model(a[6:1]), "R6", "read byte",
                        bus_dout, rd_model(a[6:1]));
                end
            end else begin
                exp_rst_n = (k == 3);
                chk(got_req == 1'b0, "R7", "no request on strobe", got_req, 0);
                chk(ext_reset_n == exp_rst_n, "R7", "reset line", ext_reset_n, exp_rst_n);
            end
        end
        @(negedge clk);
        as_n  = 1'b1;
        ds0_n = 1'b1;
        repeat (2) @(posedge clk);
        #1 chk(dtack_n == 1'b1, "R9", "DTACK released", dtack_n, 1);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(dtack_n == 1'b1, "R9", "reset dtack_n", dtack_n, 1);
        chk(req_valid == 1'b0, "R5", "reset req_valid", req_valid, 0);
        chk(bus_doe == 1'b0, "R6", "reset bus_doe", bus_doe, 0);
        chk(ext_reset_n == 1'b0, "R7", "reset ext_reset_n", ext_reset_n, 0);

        // Directed corners, window at 1000H
        bus_cycle(16'h1001, 6'h2D, 1, 0, 8'h00, "R4");   // bank 0 read
        bus_cycle(16'h107F, 6'h2D, 1, 1, 8'hC3, "R4");   // bank 63 write
        bus_cycle(16'h1019, 6'h2D, 1, 0, 8'h00, "R4");   // bank 12 read
        bus_cycle(16'h1018, 6'h2D, 1, 1, 8'h7E, "R3");   // word access -> bank 12
        bus_cycle(16'h1018, 6'h2D, 0, 1, 8'h7E, "R3");   // even lane only
        bus_cycle(16'h1081, 6'h2D, 1, 0, 8'h00, "R8");   // read of strobe
        bus_cycle(16'h10C1, 6'h2D, 1, 1, 8'h00, "R7");   // release reset
        bus_cycle(16'h1081, 6'h2D, 1, 1, 8'h00, "R7");   // assert reset
        bus_cycle(16'h10C1, 6'h2D, 1, 0, 8'h00, "R8");   // read of strobe
        bus_cycle(16'h1083, 6'h2D, 1, 1, 8'h11, "R8");   // first gap offset
        bus_cycle(16'h1101, 6'h2D, 1, 1, 8'h11, "R8");   // far offset
        bus_cycle(16'h1401, 6'h2D, 1, 0, 8'h00, "R1");   // wrong window
        bus_cycle(16'h1005, 6'h29, 1, 0, 8'h00, "R2");   // user AM refused
        bus_cycle(16'h1005, 6'h3D, 1, 0, 8'h00, "R2");   // foreign AM
        sup_only = 1'b0;
        bus_cycle(16'h1005, 6'h29, 1, 0, 8'h00, "R2");   // user AM accepted
        bus_cycle(16'h1007, 6'h2D, 1, 1, 8'h5F, "R2");
        bus_cycle(16'h10C1, 6'h29, 1, 1, 8'h00, "R7");

        // Constrained random traffic
        for (int i = 0; i < 160; i++) begin
            logic [15:0] a;
            logic [5:0]  m;
            bit          ds0;
            bit          wr;
            int          sel;
            if (i == 80) begin
                base_sel = 6'h3F;
                sup_only = 1'b1;
            end
            a[15:10] = ($urandom_range(0, 9) < 8) ? base_sel : 6'($urandom);
            sel = $urandom_range(0, 9);
            if (sel < 6)       a[9:0] = {3'b000, 6'($urandom), 1'b1};
            else if (sel == 6) a[9:0] = 10'h081;
            else if (sel == 7) a[9:0] = 10'h0C1;
            else               a[9:0] = {9'($urandom), 1'b1};
            if ($urandom_range(0, 1) == 1) a[0] = 1'b0;      // word access
            sel = $urandom_range(0, 9);
            m   = (sel < 5) ? 6'h2D : (sel < 8) ? 6'h29 : 6'($urandom);
            ds0 = ($urandom_range(0, 9) != 0);
            wr  = $urandom_range(0, 1) == 1;
            bus_cycle(a, m, ds0, wr, 8'($urandom), "R1");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule